// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is a serial test register wrapped around a device core. Every primary input pin has an input cell placed between the pin and the core. Every primary output pin has an output cell placed between the core and the pin. All cells are linked into one shift path that runs from a serial test input to a serial test output. A test access controller outside this block drives the shift, capture, update and mode controls. In this project the testbench drives them directly.

Each cell has two flops. The shift stage takes either a parallel snapshot or the bit from its upstream neighbour. The update latch copies the shift stage on request. A mode select then chooses whether the cell's parallel output carries functional data or the latched test value. With mode low the chain does not change what the core sees or what the pins show. With mode high it can force known values onto the core inputs and the output pins. The chain length is the number of input cells plus the number of output cells. Both counts are parameters, and each must be at least 1.

All controls are sampled on the rising edge of `clk`, which stands for the test clock. `dr_clk_en` plays the role of the data-register clock: when it is low at an edge, the shift stages do not change.

Top module: `bscan_chain`

## Requirements
- R1: After `rst_n` is asserted (active low), every shift stage, every update latch and `tdo` read 0. With `test_mode`=1 this shows as `core_in`=0 and `pin_out`=0.
- R2: With `test_mode`=0, `core_in` equals `pin_in` and `pin_out` equals `core_out` at all times, whatever the other scan controls do.
- R3: A rising edge with `dr_clk_en`=1 and `dr_shift`=0 is a capture. Shift stage k (k < N_IN) loads `pin_in[k]`, and shift stage N_IN+j loads `core_out[j]`.
- R4: A rising edge with `dr_clk_en`=1 and `dr_shift`=1 is a shift. Stage 0 loads `tdi`, stage k loads the old stage k-1, and `tdo` loads the old value of the last stage (stage N_IN+M_OUT-1, the cell for `pin_out[M_OUT-1]`). Input cells come first from `tdi`, so a bit entered at `tdi` reaches `tdo` after N_IN+M_OUT+1 shift edges.
- R5: A rising edge with `dr_update`=1 copies every shift stage into its update latch. When a shift or capture happens on the same edge, the latch receives the value the stage held before that edge.
- R6: With `test_mode`=1, `core_in[k]` shows update latch k and `pin_out[j]` shows update latch N_IN+j.
- R7: With `dr_clk_en`=0 the shift stages hold their values. `tdo` changes only on a shift edge. With `dr_update`=0 the update latches hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dr_clk_en | input | 1 | Enables the shift stages on this edge |
| dr_shift | input | 1 | 1 selects serial shift, 0 selects parallel capture |
| dr_update | input | 1 | Copies the shift stages into the update latches |
| test_mode | input | 1 | 0 selects functional pass-through, 1 selects the latched test values |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out (registered) |
| pin_in | input | N_IN | Device input pins |
| core_in | output | N_IN | Values delivered to the core inputs |
| core_out | input | M_OUT | Values the core drives toward the output pins |
| pin_out | output | M_OUT | Device output pins |

## Verification
The hardest case to reach is an update that lands on the same edge as a shift or a capture. Here the latch must take the stage's old value, not the new one. That difference only shows once `test_mode` is raised on a later cycle. The bench drives an edge with shift and update both set. It then drops every control and raises the mode, so the pre-edge stage contents become visible on `core_in` and `pin_out`. A cycle-level reference model of the chain, kept in the bench, predicts `tdo` and both parallel outputs for every edge of the run.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // What a shift stage does on the coming edge
  typedef enum logic [1:0] {
    CELL_HOLD    = 2'd0,
    CELL_CAPTURE = 2'd1,
    CELL_SHIFT   = 2'd2
  } cell_op_e;

  function automatic int chain_len(input int n_in, input int m_out);
    return n_in + m_out;
  endfunction

  function automatic cell_op_e decode_op(input logic clk_en, input logic shift);
    if (!clk_en)    return CELL_HOLD;
    else if (shift) return CELL_SHIFT;
    else            return CELL_CAPTURE;
  endfunction

  // Next value of a shift stage
  function automatic logic stage_next(input cell_op_e op, input logic cur,
                                      input logic ser_in, input logic par_in);
    case (op)
      CELL_SHIFT:   return ser_in;
      CELL_CAPTURE: return par_in;
      default:      return cur;
    endcase
  endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cell_op_e op,
  input  logic     upd,
  input  logic     mode,
  input  logic     ser_in,
  input  logic     par_in,
  output logic     ser_out,
  output logic     par_out
);

  logic stage_q;
  logic latch_q;
  logic stage_d;

  // Named events for the assertions
  logic ev_capture;
  logic ev_shift;
  logic ev_hold;

  assign ev_capture = (op == CELL_CAPTURE);
  assign ev_shift   = (op == CELL_SHIFT);
  assign ev_hold    = (op == CELL_HOLD);

  assign stage_d = stage_next(op, stage_q, ser_in, par_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 1'b0;
    else        stage_q <= stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   latch_q <= 1'b0;
    else if (upd) latch_q <= stage_q;
  end

  assign ser_out = stage_q;
  assign par_out = mode ? latch_q : par_in;

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |=> stage_q == $past(par_in));

  assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift |=> stage_q == $past(ser_in));

  assert_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> latch_q == $past(stage_q));

  assert_stage_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> $stable(stage_q));

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(latch_q));

endmodule

// File: rtl/bscan_tdo_stage.sv
module bscan_tdo_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_fire,
  input  logic last_bit,
  output logic tdo
);

  logic tdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tdo_q <= 1'b0;
    else if (shift_fire) tdo_q <= last_bit;
  end

  assign tdo = tdo_q;

  assert_tdo_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> tdo == $past(last_bit));

  assert_tdo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_fire |=> $stable(tdo));

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int M_OUT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dr_clk_en,
  input  logic             dr_shift,
  input  logic             dr_update,
  input  logic             test_mode,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [M_OUT-1:0] core_out,
  output logic [M_OUT-1:0] pin_out
);

  localparam int LEN = chain_len(N_IN, M_OUT);

  cell_op_e       op;
  logic           shift_fire;
  logic [LEN-1:0] scan_q;
  logic [LEN-1:0] par_in_v;
  logic [LEN-1:0] par_out_v;

  assign op         = decode_op(dr_clk_en, dr_shift);
  assign shift_fire = (op == CELL_SHIFT);

  // Parallel side: input cells first, then output cells
  assign par_in_v = {core_out, pin_in};
  assign core_in  = par_out_v[N_IN-1:0];
  assign pin_out  = par_out_v[LEN-1:N_IN];

  for (genvar k = 0; k < LEN; k++) begin : g_cell
    logic si;
    if (k == 0) begin : g_head
      assign si = tdi;
    end else begin : g_link
      assign si = scan_q[k-1];
    end

    bscan_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .upd     (dr_update),
      .mode    (test_mode),
      .ser_in  (si),
      .par_in  (par_in_v[k]),
      .ser_out (scan_q[k]),
      .par_out (par_out_v[k])
    );
  end

  bscan_tdo_stage u_tdo (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_fire (shift_fire),
    .last_bit   (scan_q[LEN-1]),
    .tdo        (tdo)
  );

  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (core_in == pin_in) && (pin_out == core_out));

  assert_chain_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> scan_q[LEN-1:1] == $past(scan_q[LEN-2:0]));

endmodule

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;

  localparam int N   = 4;
  localparam int M   = 3;
  localparam int LEN = N + M;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dr_clk_en = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, test_mode = 1'b0;
  logic         tdi = 1'b0;
  logic         tdo;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] core_in;
  logic [M-1:0] core_out = '0;
  logic [M-1:0] pin_out;

  always #10 clk = ~clk;  // 50 MHz

  bscan_chain #(.N_IN(N), .M_OUT(M)) dut (
    .clk(clk), .rst_n(rst_n), .dr_clk_en(dr_clk_en), .dr_shift(dr_shift),
    .dr_update(dr_update), .test_mode(test_mode), .tdi(tdi), .tdo(tdo),
    .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .pin_out(pin_out)
  );

  typedef struct {
    string        req;
    logic         tdo;
    logic [N-1:0] ci;
    logic [M-1:0] po;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   fails = 0;
  bit   done = 0;

  // Reference model, written from the requirements
  logic [LEN-1:0] m_sr = '0;
  logic [LEN-1:0] m_up = '0;
  logic           m_tdo = 1'b0;

  task automatic check1(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: set the controls for one edge and push the predicted result
  task automatic step(input logic en, input logic sh, input logic up,
                      input logic md, input logic t,
                      input logic [N-1:0] pv, input logic [M-1:0] cv,
                      input string req);
    logic [LEN-1:0] old;
    exp_t e;
    @(negedge clk);
    dr_clk_en = en; dr_shift = sh; dr_update = up; test_mode = md;
    tdi = t; pin_in = pv; core_out = cv;
    old = m_sr;
    if (up) m_up = old;                   // R5: latch takes pre-edge stage
    if (en && sh) begin                   // R4
      m_tdo = old[LEN-1];
      m_sr  = {old[LEN-2:0], t};
    end else if (en) begin                // R3
      m_sr = {cv, pv};
    end
    e.req = req;
    e.tdo = m_tdo;
    e.ci  = md ? m_up[N-1:0]   : pv;      // R6 / R2
    e.po  = md ? m_up[LEN-1:N] : cv;
    q.push_back(e);
  endtask

  // Monitor: compare after every rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check1(e.req, "tdo",     {31'b0, tdo}, {31'b0, e.tdo});
        check1(e.req, "core_in", 32'(core_in), 32'(e.ci));
        check1(e.req, "pin_out", 32'(pin_out), 32'(e.po));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] pat;
    test_mode = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state seen through the latched path
    check1("R1", "tdo",     {31'b0, tdo}, 32'd0);
    check1("R1", "core_in", 32'(core_in), 32'd0);
    check1("R1", "pin_out", 32'(pin_out), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: functional pass-through under several patterns and controls
    step(0, 0, 0, 0, 0, 4'hA, 3'b101, "R2");
    step(0, 0, 0, 0, 1, 4'h5, 3'b010, "R2");
    step(1, 1, 1, 0, 1, 4'h3, 3'b110, "R2");  // scan activity, core view unchanged

    // R3 then R4: capture, then shift the whole chain out with new pins
    step(1, 0, 0, 0, 0, 4'b1101, 3'b011, "R3");
    pat = 7'b1011001;
    for (int i = 0; i < LEN; i++)
      step(1, 1, 0, 0, pat[i], 4'h0, 3'b000, "R4");
    // One more edge: the first tdi bit of this burst reaches tdo
    step(1, 1, 0, 0, 1'b0, 4'h0, 3'b000, "R4");

    // R5 then R6: update, then show latches with different pins
    step(0, 0, 1, 0, 0, 4'h6, 3'b001, "R5");
    step(0, 0, 0, 1, 0, 4'h9, 3'b110, "R6");
    step(0, 0, 0, 1, 1, 4'hF, 3'b111, "R6");

    // R7: hold with controls low, inputs toggling
    for (int i = 0; i < 4; i++)
      step(0, 1, 0, 1, i[0], 4'(i * 3), 3'(i), "R7");
    step(0, 0, 0, 0, 1, 4'h2, 3'b100, "R7");

    // R5: update on the same edge as a shift takes pre-shift stages
    step(1, 1, 1, 1, 1, 4'h1, 3'b010, "R5");
    step(0, 0, 0, 1, 0, 4'h8, 3'b001, "R5");
    // R5: update on the same edge as a capture
    step(1, 0, 1, 1, 0, 4'hC, 3'b101, "R5");
    step(0, 0, 1, 1, 0, 4'h0, 3'b000, "R5");
    step(0, 0, 0, 1, 0, 4'h7, 3'b010, "R6");

    // R4: a longer shift burst with the latched view on
    for (int i = 0; i < 2 * LEN; i++)
      step(1, 1, 0, 1, i[1] ^ i[0], 4'h0, 3'b000, "R4");
    step(0, 0, 1, 1, 0, 4'h0, 3'b000, "R5");
    step(0, 0, 0, 1, 0, 4'h0, 3'b000, "R6");

    @(posedge clk);
    #8;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule